// File: doc/BRIEF.md
# Programmable LCD Sync Timing Generator

This block produces the raster timing for an LCD panel: a line sync, a frame sync, a data-enable strobe, the position of the current active beat (column and row), a pixel clock enable and a one-cycle frame-start pulse. A host programs five registers through a single-cycle write port. Every register value goes into a shadow copy first. The whole shadow set is copied into the working configuration only when the raster wraps from the last pixel clock of a frame to the first. A frame is therefore never drawn with a mix of old and new timing.

Each line runs through four phases in order: sync, back porch, active, front porch. The frame runs through the same four phases counted in whole lines. The active phase of a line is measured in transfer beats. For a TFT panel that is the pixel count. For an STN panel the block derives it from the pixel count, the colour setting, the data bus width and the scan mode. The pixel clock enable comes from a divider of the core clock. A bypass setting makes it fire on every core clock.

Register map, with the byte address on `reg_addr`:
- 0, clock: bits [7:0] hold `div`, bit 8 holds `bypass`.
- 1, panel: bit 0 selects STN, bit 1 selects colour, bits [3:2] select the bus (0 = 4-bit, 1 = 8-bit, 2 or 3 = 16-bit), bit 4 selects dual scan, bit 5 inverts the line sync, bit 6 inverts the frame sync.
- 2, vertical: bits [7:0] hold `vpw_m1`, bits [15:8] hold `vbp`, bits [23:16] hold `vfp`.
- 3, horizontal: bits [7:0] hold `hpw_m1`, bits [15:8] hold `hbp_m1`, bits [23:16] hold `hfp_m1`.
- 4, size: bits [10:0] hold `xres` (must be at least 1), bits [26:16] hold `yact_m1`.

Reset values are all zero, except `xres` = 4 and `yact_m1` = 1.

Top module: `lcdt_sync_gen`

## Requirements
- R1: While reset is held, the outputs are: hsync = 1, vsync = 1, de = 0, col = 0, row = 0, frame_start = 0 and pixel_ce = 0.
- R2: pixel_ce is high for one core clock out of every 2×(div+1) core clocks. With bypass = 1 it is high on every core clock.
- R3: Each line lasts hpw_m1+1 pixel clocks of sync, then hbp_m1+1 of back porch, then the active beats, then hfp_m1+1 of front porch.
- R4: The line counter advances once, at the end of each full line. Each frame has vpw_m1+1 sync lines, vbp back-porch lines, yact_m1+1 active lines and vfp front-porch lines, in that order.
- R5: When the STN bit is 0 (TFT), the number of active beats per line equals xres.
- R6: When the STN bit is 1, the pixel count is first multiplied by 3 if the colour bit is 1. The result is divided by 4, rounded up, for a 4-bit bus or for an 8-bit bus in dual scan. In every other case it is divided by 8, rounded up.
- R7: The line sync and frame sync are high during their sync phases. A set invert bit makes the matching sync low during its sync phase and high at all other times.
- R8: de is high only on active beats of active lines. There, col counts 0, 1, … along the line and row counts 0, 1, … down the frame. Both are 0 whenever de is low.
- R9: frame_start is high for exactly one core clock: the first clock of each new frame after a wrap. In that clock col = 0, row = 0 and de = 0.
- R10: Register writes change the timing only at the next frame wrap. Until then, the frame in progress keeps its old timing.
- R11: The outputs hsync, vsync, de, col and row change only on core clocks that follow a clock in which pixel_ce was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| pixel_ce | output | 1 | Pixel clock enable |
| hsync | output | 1 | Line sync, polarity as programmed |
| vsync | output | 1 | Frame sync, polarity as programmed |
| de | output | 1 | Active data enable |
| col | output | 12 | Active beat index within the line |
| row | output | 11 | Active line index within the frame |
| frame_start | output | 1 | One-clock pulse at the start of each frame |

## Verification
The bound assertions check, on every cycle, the rules that hold whatever the programming:
- frame_start is a single-clock pulse, it follows a pixel enable, and it lands on the origin of the frame.
- The sync, de and position outputs hold still between pixel enables.
- col steps by one across each active run.

The exact phase lengths, the beat count for each panel type and bus mode, the sync polarities, and the rule that new settings wait for the frame wrap all depend on the programmed values. Only the bench's scenarios can show those. The bench writes new settings in the middle of a frame and compares every output against a behavioural reference model on every clock.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
    parameter int DW = 8;   // divider field width
    parameter int FW = 8;   // porch / pulse field width
    parameter int XW = 11;  // pixel count width
    parameter int YW = 11;  // active line count width
    parameter int CW = 12;  // raster counter width
    parameter int AW = 3;   // register address width
    parameter int RW = 32;  // register data width

    localparam logic [AW-1:0] A_CLK   = AW'(0);
    localparam logic [AW-1:0] A_PANEL = AW'(1);
    localparam logic [AW-1:0] A_VERT  = AW'(2);
    localparam logic [AW-1:0] A_HORZ  = AW'(3);
    localparam logic [AW-1:0] A_SIZE  = AW'(4);
    localparam int SIZE_Y_LSB = 16;

    typedef enum logic [1:0] {
        BUS4   = 2'd0,
        BUS8   = 2'd1,
        BUS16  = 2'd2,
        BUS16B = 2'd3
    } bus_e;

    typedef struct packed {
        logic          bypass;
        logic [DW-1:0] div;
        logic          stn;
        logic          colour;
        bus_e          bus;
        logic          dual;
        logic          hinv;
        logic          vinv;
        logic [FW-1:0] vpw_m1;
        logic [FW-1:0] vbp;
        logic [FW-1:0] vfp;
        logic [FW-1:0] hpw_m1;
        logic [FW-1:0] hbp_m1;
        logic [FW-1:0] hfp_m1;
        logic [XW-1:0] xres;
        logic [YW-1:0] yact_m1;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        bypass:  1'b0,
        div:     '0,
        stn:     1'b0,
        colour:  1'b0,
        bus:     BUS4,
        dual:    1'b0,
        hinv:    1'b0,
        vinv:    1'b0,
        vpw_m1:  '0,
        vbp:     '0,
        vfp:     '0,
        hpw_m1:  '0,
        hbp_m1:  '0,
        hfp_m1:  '0,
        xres:    XW'(4),
        yact_m1: YW'(1)
    };
endpackage

// File: rtl/lcdt_beat_calc.sv
module lcdt_beat_calc
    import lcdt_pkg::*;
#(
    parameter int P_XW = XW,
    parameter int P_CW = CW
) (
    input  logic            stn,
    input  logic            colour,
    input  bus_e            bus,
    input  logic            dual,
    input  logic [P_XW-1:0] xres,
    output logic [P_CW-1:0] beats
);
    localparam int SW = P_XW + 3;

    logic [SW-1:0] scaled;
    logic [SW-1:0] by4_up;
    logic [SW-1:0] by8_up;
    logic          narrow;

    always_comb begin
        // colour STN carries three sub-pixels per pixel
        scaled = SW'(xres) + (colour ? {SW'(xres), 1'b0} : '0);
        by4_up = (scaled + SW'(3)) >> 2;
        by8_up = (scaled + SW'(7)) >> 3;
        narrow = (bus == BUS4) || ((bus == BUS8) && dual);
        if (!stn)
            beats = P_CW'(xres);
        else if (narrow)
            beats = P_CW'(by4_up);
        else
            beats = P_CW'(by8_up);
    end
endmodule

// File: rtl/lcdt_pix_ce.sv
module lcdt_pix_ce #(
    parameter int P_DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [P_DW-1:0] div,
    input  logic            bypass,
    output logic            ce
);
    localparam int PW = P_DW + 1;

    typedef struct packed {
        logic [PW-1:0] cnt;
    } ce_state_t;

    ce_state_t q, d;

    // terminal count is 2*(div+1)-1
    assign ce = bypass || (q.cnt == {div, 1'b1});

    always_comb begin
        d = q;
        if (ce)
            d.cnt = '0;
        else
            d.cnt = q.cnt + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end
endmodule

// File: rtl/lcdt_raster.sv
module lcdt_raster #(
    parameter int P_FW = 8,
    parameter int P_CW = 12,
    parameter int P_YW = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ce,
    input  logic [P_FW-1:0] hpw_m1,
    input  logic [P_FW-1:0] hbp_m1,
    input  logic [P_FW-1:0] hfp_m1,
    input  logic [P_CW-1:0] beats,
    input  logic [P_FW-1:0] vpw_m1,
    input  logic [P_FW-1:0] vbp,
    input  logic [P_FW-1:0] vfp,
    input  logic [P_YW-1:0] yact_m1,
    input  logic            hinv,
    input  logic            vinv,
    output logic            hsync,
    output logic            vsync,
    output logic            de,
    output logic [P_CW-1:0] col,
    output logic [P_YW-1:0] row,
    output logic            frame_start,
    output logic            frame_wrap
);
    typedef struct packed {
        logic [P_CW-1:0] h;
        logic [P_CW-1:0] v;
        logic            fs;
    } ras_state_t;

    ras_state_t q, d;

    logic [P_CW-1:0] h_sync_end, h_act_start, h_act_end, h_last;
    logic [P_CW-1:0] v_sync_end, v_act_start, v_act_end, v_last;
    logic            line_end, h_on, v_on;

    always_comb begin
        h_sync_end  = P_CW'(hpw_m1) + P_CW'(1);
        h_act_start = h_sync_end + P_CW'(hbp_m1) + P_CW'(1);
        h_act_end   = h_act_start + beats;
        h_last      = h_act_end + P_CW'(hfp_m1);

        v_sync_end  = P_CW'(vpw_m1) + P_CW'(1);
        v_act_start = v_sync_end + P_CW'(vbp);
        v_act_end   = v_act_start + P_CW'(yact_m1) + P_CW'(1);
        v_last      = v_act_end + P_CW'(vfp) - P_CW'(1);

        line_end   = ce && (q.h == h_last);
        frame_wrap = line_end && (q.v == v_last);

        h_on = (q.h >= h_act_start) && (q.h < h_act_end);
        v_on = (q.v >= v_act_start) && (q.v < v_act_end);
    end

    always_comb begin
        d    = q;
        d.fs = frame_wrap;
        if (line_end) begin
            d.h = '0;
            d.v = frame_wrap ? '0 : q.v + P_CW'(1);
        end else if (ce) begin
            d.h = q.h + P_CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign hsync       = (q.h < h_sync_end) ^ hinv;
    assign vsync       = (q.v < v_sync_end) ^ vinv;
    assign de          = h_on && v_on;
    assign col         = de ? (q.h - h_act_start) : '0;
    assign row         = de ? P_YW'(q.v - v_act_start) : '0;
    assign frame_start = q.fs;
endmodule

// File: rtl/lcdt_sync_gen.sv
module lcdt_sync_gen
    import lcdt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [RW-1:0] reg_wdata,
    output logic          pixel_ce,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic [CW-1:0] col,
    output logic [YW-1:0] row,
    output logic          frame_start
);
    typedef struct packed {
        cfg_t shadow;
        cfg_t active;
    } regs_t;

    regs_t         q, d;
    logic          frame_wrap;
    logic [CW-1:0] beats;
    logic          unused_wdata;

    assign unused_wdata = ^reg_wdata;

    always_comb begin
        d = q;
        if (frame_wrap)
            d.active = q.shadow;
        if (reg_we) begin
            case (reg_addr)
                A_CLK: begin
                    d.shadow.div    = reg_wdata[DW-1:0];
                    d.shadow.bypass = reg_wdata[DW];
                end
                A_PANEL: begin
                    d.shadow.stn    = reg_wdata[0];
                    d.shadow.colour = reg_wdata[1];
                    d.shadow.bus    = bus_e'(reg_wdata[3:2]);
                    d.shadow.dual   = reg_wdata[4];
                    d.shadow.hinv   = reg_wdata[5];
                    d.shadow.vinv   = reg_wdata[6];
                end
                A_VERT: begin
                    d.shadow.vpw_m1 = reg_wdata[FW-1:0];
                    d.shadow.vbp    = reg_wdata[2*FW-1:FW];
                    d.shadow.vfp    = reg_wdata[3*FW-1:2*FW];
                end
                A_HORZ: begin
                    d.shadow.hpw_m1 = reg_wdata[FW-1:0];
                    d.shadow.hbp_m1 = reg_wdata[2*FW-1:FW];
                    d.shadow.hfp_m1 = reg_wdata[3*FW-1:2*FW];
                end
                A_SIZE: begin
                    d.shadow.xres    = reg_wdata[XW-1:0];
                    d.shadow.yact_m1 = reg_wdata[SIZE_Y_LSB +: YW];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '{shadow: CFG_RESET, active: CFG_RESET};
        else
            q <= d;
    end

    lcdt_beat_calc #(.P_XW(XW), .P_CW(CW)) u_beats (
        .stn    (q.active.stn),
        .colour (q.active.colour),
        .bus    (q.active.bus),
        .dual   (q.active.dual),
        .xres   (q.active.xres),
        .beats  (beats)
    );

    lcdt_pix_ce #(.P_DW(DW)) u_ce (
        .clk    (clk),
        .rst_n  (rst_n),
        .div    (q.active.div),
        .bypass (q.active.bypass),
        .ce     (pixel_ce)
    );

    lcdt_raster #(.P_FW(FW), .P_CW(CW), .P_YW(YW)) u_raster (
        .clk         (clk),
        .rst_n       (rst_n),
        .ce          (pixel_ce),
        .hpw_m1      (q.active.hpw_m1),
        .hbp_m1      (q.active.hbp_m1),
        .hfp_m1      (q.active.hfp_m1),
        .beats       (beats),
        .vpw_m1      (q.active.vpw_m1),
        .vbp         (q.active.vbp),
        .vfp         (q.active.vfp),
        .yact_m1     (q.active.yact_m1),
        .hinv        (q.active.hinv),
        .vinv        (q.active.vinv),
        .hsync       (hsync),
        .vsync       (vsync),
        .de          (de),
        .col         (col),
        .row         (row),
        .frame_start (frame_start),
        .frame_wrap  (frame_wrap)
    );
endmodule

// File: rtl/lcdt_sync_chk.sv
module lcdt_sync_chk #(
    parameter int P_CW = 12,
    parameter int P_YW = 11
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pixel_ce,
    input logic            hsync,
    input logic            vsync,
    input logic            de,
    input logic [P_CW-1:0] col,
    input logic [P_YW-1:0] row,
    input logic            frame_start
);
    // R9
    fs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    // R9
    fs_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (col == '0 && row == '0 && !de));

    // R9
    fs_after_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> $past(pixel_ce));

    // R11
    hold_between_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pixel_ce |=> $stable({hsync, vsync, de, col, row}));

    // R8
    col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (de && pixel_ce) |=> (!de || col == P_CW'($past(col) + 1'b1)));
endmodule

bind lcdt_sync_gen lcdt_sync_chk #(.P_CW(lcdt_pkg::CW), .P_YW(lcdt_pkg::YW)) u_sync_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pixel_ce    (pixel_ce),
    .hsync       (hsync),
    .vsync       (vsync),
    .de          (de),
    .col         (col),
    .row         (row),
    .frame_start (frame_start)
);

// File: tb/tb_lcdt_sync_gen.sv
`timescale 1ns/1ps
module tb_lcdt_sync_gen;
    import lcdt_pkg::*;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [RW-1:0] reg_wdata = '0;
    logic          pixel_ce, hsync, vsync, de, frame_start;
    logic [CW-1:0] col;
    logic [YW-1:0] row;

    always #4 clk = ~clk;

    lcdt_sync_gen dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .pixel_ce(pixel_ce), .hsync(hsync),
        .vsync(vsync), .de(de), .col(col), .row(row),
        .frame_start(frame_start)
    );

    typedef struct {
        int div, bypass, stn, colour, bus, dual, hinv, vinv;
        int vpw, vbp, vfp, hpw, hbp, hfp, xres, yact;
    } mcfg_t;

    mcfg_t sh, ac;
    int m_cnt, m_h, m_v, m_fs;
    int vectors = 0, fails = 0;
    int run_len = 0;
    logic prev_de = 1'b0;
    bit done = 0;

    function automatic mcfg_t reset_cfg();
        mcfg_t c;
        c = '{default: 0};
        c.xres = 4;
        c.yact = 1;
        return c;
    endfunction

    function automatic int m_beats(mcfg_t c);
        int s;
        if (c.stn == 0) return c.xres;
        s = (c.colour != 0) ? 3 * c.xres : c.xres;
        if (c.bus == 0 || (c.bus == 1 && c.dual != 0)) return (s + 3) / 4;
        return (s + 7) / 8;
    endfunction

    function automatic int m_ce();
        return (ac.bypass != 0 || m_cnt == 2 * ac.div + 1) ? 1 : 0;
    endfunction

    task automatic check(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    // compare every output against the reference model state
    task automatic compare_all();
        int a0, a1, va0, va1, beats, on;
        beats = m_beats(ac);
        a0  = (ac.hpw + 1) + (ac.hbp + 1);
        a1  = a0 + beats;
        va0 = (ac.vpw + 1) + ac.vbp;
        va1 = va0 + ac.yact + 1;
        on  = (m_h >= a0 && m_h < a1 && m_v >= va0 && m_v < va1) ? 1 : 0;
        check("R2 pixel_ce", int'(pixel_ce), m_ce());
        check("R3/R7/R10 hsync", int'(hsync), ((m_h < ac.hpw + 1) ? 1 : 0) ^ ac.hinv);
        check("R4/R7/R10 vsync", int'(vsync), ((m_v < ac.vpw + 1) ? 1 : 0) ^ ac.vinv);
        check("R8/R11 de", int'(de), on);
        check("R8 col", int'(col), on ? m_h - a0 : 0);
        check("R4/R8 row", int'(row), on ? m_v - va0 : 0);
        check("R9 frame_start", int'(frame_start), m_fs);
        // beats per line, counted at the ports
        if (de && pixel_ce) run_len++;
        if (!de && prev_de) begin
            check(ac.stn != 0 ? "R6 beats per line" : "R5 beats per line", run_len, beats);
            run_len = 0;
        end
        prev_de = de;
    endtask

    task automatic apply_write(int addr, int data);
        case (addr)
            0: begin sh.div = data & 255; sh.bypass = (data >> 8) & 1; end
            1: begin
                sh.stn = data & 1; sh.colour = (data >> 1) & 1;
                sh.bus = (data >> 2) & 3; sh.dual = (data >> 4) & 1;
                sh.hinv = (data >> 5) & 1; sh.vinv = (data >> 6) & 1;
            end
            2: begin sh.vpw = data & 255; sh.vbp = (data >> 8) & 255; sh.vfp = (data >> 16) & 255; end
            3: begin sh.hpw = data & 255; sh.hbp = (data >> 8) & 255; sh.hfp = (data >> 16) & 255; end
            4: begin sh.xres = data & 2047; sh.yact = (data >> 16) & 2047; end
            default: ;
        endcase
    endtask

    task automatic advance(bit we, int addr, int data);
        int htot, vtot, fs_n;
        htot = (ac.hpw + 1) + (ac.hbp + 1) + m_beats(ac) + (ac.hfp + 1);
        vtot = (ac.vpw + 1) + ac.vbp + (ac.yact + 1) + ac.vfp;
        fs_n = 0;
        if (m_ce() != 0) begin
            m_cnt = 0;
            if (m_h == htot - 1) begin
                m_h = 0;
                if (m_v == vtot - 1) begin
                    m_v = 0;
                    fs_n = 1;
                    ac = sh;
                end else begin
                    m_v++;
                end
            end else begin
                m_h++;
            end
        end else begin
            m_cnt++;
        end
        if (we) apply_write(addr, data);
        m_fs = fs_n;
    endtask

    task automatic step(bit we, int addr, int data);
        @(negedge clk);
        compare_all();
        reg_we    = we;
        reg_addr  = AW'(addr);
        reg_wdata = RW'(data);
        advance(we, addr, data);
    endtask

    task automatic run_frames(int n);
        int seen = 0;
        while (seen < n && !done) begin
            step(0, 0, 0);
            if (m_fs != 0) seen++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        sh = reset_cfg();
        ac = reset_cfg();
        m_cnt = 0; m_h = 0; m_v = 0; m_fs = 0;
        repeat (3) @(negedge clk);
        // R1: outputs while reset is held
        check("R1 hsync", int'(hsync), 1);
        check("R1 vsync", int'(vsync), 1);
        check("R1 de", int'(de), 0);
        check("R1 col", int'(col), 0);
        check("R1 row", int'(row), 0);
        check("R1 frame_start", int'(frame_start), 0);
        check("R1 pixel_ce", int'(pixel_ce), 0);
        rst_n = 1'b1;
        advance(0, 0, 0);

        // default frame: TFT, 4 beats, 2 lines
        run_frames(2);

        // R10: rewrite everything in mid-frame, old timing continues
        repeat (5) step(0, 0, 0);
        step(1, 0, 1);                             // div = 1
        step(1, 1, 32'h60);                        // both syncs inverted
        step(1, 2, 1 | (1 << 8) | (2 << 16));
        step(1, 3, 1 | (2 << 8));
        step(1, 4, 5 | (2 << 16));
        run_frames(2);

        // R6: STN mono, 4-bit bus, xres 10 -> 3 beats
        step(1, 0, 0);
        step(1, 1, 32'h01);
        step(1, 4, 10 | (2 << 16));
        run_frames(2);
        // R6: STN colour, 8-bit single scan, xres 5 -> 2 beats
        step(1, 1, 32'h07);
        step(1, 4, 5 | (1 << 16));
        run_frames(2);
        // R6: STN colour, 8-bit dual scan, xres 5 -> 4 beats
        step(1, 1, 32'h17);
        run_frames(2);
        // R6: STN mono, 16-bit bus, xres 9 -> 2 beats
        step(1, 1, 32'h09);
        step(1, 4, 9 | (1 << 16));
        run_frames(2);

        // R2: bypass, TFT, xres 6, line sync inverted only
        step(1, 0, 1 << 8);
        step(1, 1, 32'h20);
        step(1, 4, 6 | (2 << 16));
        run_frames(2);

        // R2: large divider, period 12
        step(1, 0, 5);
        step(1, 1, 32'h40);
        run_frames(2);

        if (!done) begin
            done = 1;
            summary();
            $finish;
        end
    end
endmodule